// File: doc/BRIEF.md
# I2C Addressed Slave with Clock Stretching

This block is a processor-serviced I2C target. It watches the sampled SCL and SDA lines for START and STOP conditions, shifts in the 7-bit address and direction bit that follow each START, and compares the address with a programmable own-address register. On a match it answers with ACK, records the direction, and then pauses the bus by holding SCL low until software has dealt with the transfer.

Software works through a small register port. For a write transfer it reads each received byte and then acknowledges the pause by writing the status register. For a read transfer it loads the next byte to send and then writes the status register. The slave drives only pull-down enables for both lines, so the wired-AND bus is formed outside the block. An interrupt follows the ready flag when it is enabled. A control bit lets software refuse traffic by answering NACK.

Register map (3-bit offset): 0 control (bit0 enable, bit1 refuse/NACK, bit2 interrupt enable), 1 own address (bits 6:0), 2 received byte (read), 3 byte to send, 4 status (bit0 ready, bit1 direction, bit2 master NACK; any write releases the pause).

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset both pull-down enables are low, the interrupt is low, and status and control read as 0.
- R2: A START while enabled (control bit0 = 1) begins address reception. The slave answers ACK (SDA pulled low on the ninth clock) only when the seven address bits, MSB first, equal the own-address register and control bit1 is 0. A repeated START restarts address reception at any time.
- R3: On an address mismatch, or while disabled, the slave answers NACK, leaves SDA and SCL released, and keeps ready at 0 until the next START.
- R4: On an address match, the eighth received bit (1 = read) is held in status bit1 for the whole transfer.
- R5: After each acknowledged address or data byte and its ninth clock, the slave holds SCL low and status bit0 (ready) reads 1 until software writes offset 4. The interrupt equals ready AND control bit2.
- R6: In a write transfer each byte is shifted in MSB first, answered with ACK, and readable at offset 2 while the slave holds SCL.
- R7: With control bit1 = 1 an address is not acknowledged. A data byte in a write transfer gets NACK, is not stored at offset 2, and no pause follows. The slave then stays silent until the next START.
- R8: In a read transfer the byte at offset 3 is sent MSB first once software releases the pause. A master ACK clears status bit2 and leads to a new pause. A master NACK sets status bit2, leaves ready at 0 and releases both lines.
- R9: A STOP returns the slave to idle from any state, including mid-byte. Bits clocked without a new START are then ignored.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that SDA changes only while SCL is low, except for START and STOP. They assume that each level on either line lasts longer than the synchronizer plus deglitch window, and that software does not rewrite the own-address or control registers while an address byte is being acknowledged. The bench master keeps to this. It spaces every line change by a quarter bit of twenty clocks, changes data only with SCL low, waits on the real SCL level before each high phase so that stretching is honoured, and reprograms registers only while the slave is idle or pausing the bus.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK,
    ST_TX, ST_TX_ACK, ST_HOLD, ST_SKIP
  } eng_state_t;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_OWN  = 3'd1;
  localparam logic [2:0] RA_RXD  = 3'd2;
  localparam logic [2:0] RA_TXD  = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd4;

  localparam int CB_EN   = 0;
  localparam int CB_NACK = 1;
  localparam int CB_IEN  = 2;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level_q, level_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   samp;

  assign samp = sync_q[SYNC_STAGES-1];

  always_comb begin
    level_d = level_q;
    cnt_d   = cnt_q;
    if (samp == level_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      level_d = samp;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      level_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], pin_i};
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level_o = level_q;

  // R2: the filtered level only moves to a value the synchronizer presented
  p_filter_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(samp) == level_q));
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          slave_en,
  input  logic          nack_ctl,
  input  logic [AW-1:0] own_addr,
  input  logic [DW-1:0] tx_data,
  input  logic          cpu_release,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          ready,
  output logic          dir,
  output logic          mstr_nack,
  output logic [DW-1:0] rx_data
);
  localparam int FRAME = AW + 1;
  localparam int SH_W  = (DW > FRAME) ? DW : FRAME;
  localparam int CW    = $clog2(SH_W + 1);

  eng_state_t    state_q, state_d;
  logic [SH_W-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sda_q, sda_d;
  logic          ready_q, ready_d;
  logic          dir_q, dir_d;
  logic          mnack_q, mnack_d;
  logic [DW-1:0] rx_q, rx_d;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    sda_d   = sda_q;
    ready_d = ready_q;
    dir_d   = dir_q;
    mnack_d = mnack_q;
    rx_d    = rx_q;
    if (cpu_release) ready_d = 1'b0;

    if (stop_ev || !slave_en) begin
      state_d = ST_IDLE;
      sda_d   = 1'b0;
      cnt_d   = '0;
    end else if (start_ev) begin
      state_d = ST_ADDR;
      sda_d   = 1'b0;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[SH_W-2:0], sda_f};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CW'(FRAME)) begin
            if (sh_q[AW:1] == own_addr && !nack_ctl) begin
              state_d = ST_ADDR_ACK;
              sda_d   = 1'b1;
              dir_d   = sh_q[0];
              mnack_d = 1'b0;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK, ST_RX_ACK: begin
          if (scl_fall) begin
            sda_d   = 1'b0;
            ready_d = 1'b1;
            state_d = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (cpu_release) begin
            cnt_d = '0;
            if (dir_q) begin
              state_d = ST_TX;
              sh_d    = SH_W'(tx_data);
              sda_d   = ~tx_data[DW-1];
            end else begin
              state_d = ST_RX;
              sda_d   = 1'b0;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[SH_W-2:0], sda_f};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CW'(DW)) begin
            if (!nack_ctl) begin
              rx_d    = sh_q[DW-1:0];
              sda_d   = 1'b1;
              state_d = ST_RX_ACK;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == CW'(DW)) begin
              sda_d   = 1'b0;
              state_d = ST_TX_ACK;
            end else begin
              sh_d  = sh_q << 1;
              sda_d = ~sh_q[DW-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mnack_d = sda_f;
          end else if (scl_fall) begin
            if (mnack_q) begin
              state_d = ST_SKIP;
            end else begin
              ready_d = 1'b1;
              state_d = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      sda_q   <= 1'b0;
      ready_q <= 1'b0;
      dir_q   <= 1'b0;
      mnack_q <= 1'b0;
      rx_q    <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      sda_q   <= sda_d;
      ready_q <= ready_d;
      dir_q   <= dir_d;
      mnack_q <= mnack_d;
      rx_q    <= rx_d;
    end
  end

  assign scl_oe    = (state_q == ST_HOLD);
  assign sda_oe    = sda_q;
  assign ready     = ready_q;
  assign dir       = dir_q;
  assign mstr_nack = mnack_q;
  assign rx_data   = rx_q;

  // R2: the address acknowledge is only driven for a matching address
  p_ack_needs_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_ACK) |-> (sh_q[AW:1] == own_addr));
  // R3: an unaddressed slave keeps SDA released
  p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !sda_q);
  // R4: the direction does not move while the bus is paused
  p_dir_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> $stable(dir_q));
  // R5: SCL is only stretched while ready is raised
  p_hold_has_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> ready_q);
  // R5: a software release ends the pause
  p_release_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && cpu_release && slave_en) |=> (!ready_q && state_q != ST_HOLD));
  // R9: STOP always returns to idle
  p_stop_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state_q == ST_IDLE));
  // R10: SDA drive is steady while SCL stays high
  p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_q));
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
#(
  parameter int AW  = 7,
  parameter int DW  = 8,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] reg_addr,
  input  logic           reg_wr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           st_ready,
  input  logic           st_dir,
  input  logic           st_mnack,
  input  logic [DW-1:0]  st_rx,
  output logic           slave_en,
  output logic           nack_ctl,
  output logic           irq_en,
  output logic [AW-1:0]  own_addr,
  output logic [DW-1:0]  tx_data,
  output logic           cpu_release
);
  localparam int CTRL_W = 3;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [AW-1:0]     own_q, own_d;
  logic [DW-1:0]     txd_q, txd_d;
  logic [2:0]        off;

  assign off = 3'(reg_addr);

  always_comb begin
    ctrl_d = ctrl_q;
    own_d  = own_q;
    txd_d  = txd_q;
    if (reg_wr) begin
      unique case (off)
        RA_CTRL: ctrl_d = reg_wdata[CTRL_W-1:0];
        RA_OWN:  own_d  = reg_wdata[AW-1:0];
        RA_TXD:  txd_d  = reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      own_q  <= '0;
      txd_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      own_q  <= own_d;
      txd_q  <= txd_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (off)
      RA_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
      RA_OWN:  reg_rdata[AW-1:0]     = own_q;
      RA_RXD:  reg_rdata             = st_rx;
      RA_TXD:  reg_rdata             = txd_q;
      RA_STAT: reg_rdata[2:0]        = {st_mnack, st_dir, st_ready};
      default: ;
    endcase
  end

  assign cpu_release = reg_wr && (off == RA_STAT);
  assign slave_en    = ctrl_q[CB_EN];
  assign nack_ctl    = ctrl_q[CB_NACK];
  assign irq_en      = ctrl_q[CB_IEN];
  assign own_addr    = own_q;
  assign tx_data     = txd_q;
endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave #(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int RAW      = 3,
  parameter int FILT_CYC = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] reg_addr,
  input  logic           reg_wr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           scl_oe,
  output logic           sda_oe,
  output logic           irq
);
  localparam int NPIN = 2;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [NPIN-1:0] pin_raw, pin_flt;
  assign pin_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_flt
    i2cs_line_filter #(.SYNC_STAGES(2), .FILT_CYC(FILT_CYC)) u_flt (
      .clk(clk), .rst_n(rst_n_int), .pin_i(pin_raw[g]), .level_o(pin_flt[g])
    );
  end

  logic scl_rise, scl_fall, start_ev, stop_ev;
  i2cs_bus_events u_evt (
    .clk(clk), .rst_n(rst_n_int), .scl_f(pin_flt[0]), .sda_f(pin_flt[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  logic          slave_en, nack_ctl, irq_en, cpu_release;
  logic [AW-1:0] own_addr;
  logic [DW-1:0] tx_data, rx_data;
  logic          ready, dir, mstr_nack;

  i2cs_regs #(.AW(AW), .DW(DW), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st_ready(ready), .st_dir(dir),
    .st_mnack(mstr_nack), .st_rx(rx_data), .slave_en(slave_en), .nack_ctl(nack_ctl),
    .irq_en(irq_en), .own_addr(own_addr), .tx_data(tx_data), .cpu_release(cpu_release)
  );

  i2cs_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n_int), .scl_f(pin_flt[0]), .sda_f(pin_flt[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .slave_en(slave_en), .nack_ctl(nack_ctl), .own_addr(own_addr), .tx_data(tx_data),
    .cpu_release(cpu_release), .scl_oe(scl_oe), .sda_oe(sda_oe), .ready(ready),
    .dir(dir), .mstr_nack(mstr_nack), .rx_data(rx_data)
  );

  assign irq = ready & irq_en;
endmodule

// File: tb/i2c_stretch_slave_tb_top.sv
module i2c_stretch_slave_tb_top;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe, irq;
  logic       m_scl_low = 1'b0;
  logic       m_sda_low = 1'b0;
  logic       scl_line, sda_line;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  always #5 clk = ~clk;

  i2c_stretch_slave dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  typedef struct { string req; int val; } exp_t;
  exp_t exp_q[$];
  int   obs_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   r10_viol = 0;
  bit   done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0) begin
        int o;
        o = obs_q.pop_front();
        if (exp_q.size() == 0) chk("scoreboard-underflow", o, -1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.req, o, e.val);
        end
      end
    end
  end

  // R10 watcher at the pins
  initial begin
    logic ps, po;
    ps = 1'b1; po = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && ps && scl_line && (po != sda_oe)) r10_viol++;
      ps = scl_line; po = sda_oe;
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; wait_q();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_q();
    m_sda_low = 1'b1; wait_q();
    m_scl_low = 1'b1; wait_q();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wait_q();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_q();
    m_sda_low = 1'b0; wait_q();
  endtask

  task automatic clock_bit(input logic b, output logic r);
    m_sda_low = !b; wait_q();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_q();
    r = sda_line;
    wait_q();
    m_scl_low = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, input string req, input int exp_ack);
    logic r;
    exp_q.push_back('{req: req, val: exp_ack});
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    obs_q.push_back(int'(!r));
  endtask

  task automatic recv_byte(input logic give_nack, input string req, input int exp_val);
    logic r;
    logic [7:0] d;
    exp_q.push_back('{req: req, val: exp_val});
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, r);
      d[i] = r;
    end
    clock_bit(give_nack, r);
    obs_q.push_back(int'(d));
  endtask

  initial begin
    logic [7:0] rd;
    logic r;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    reg_read(3'd4, rd); chk("R1 status", rd, 0);
    reg_read(3'd0, rd); chk("R1 control", rd, 0);
    chk("R1 pulls", {scl_oe, sda_oe}, 0);
    chk("R1 irq", irq, 0);

    reg_write(3'd0, 8'h05);
    reg_write(3'd1, 8'h3A);

    // write transfer: R2 R4 R5 R6
    bus_start();
    send_byte(8'h74, "R2 address ack", 1);
    chk("R5 stretch", scl_oe, 1);
    reg_read(3'd4, rd); chk("R4 R5 status write", rd, 8'h01);
    chk("R5 irq", irq, 1);
    reg_write(3'd4, 8'h00);
    chk("R5 release scl", scl_oe, 0);
    chk("R5 irq clear", irq, 0);
    send_byte(8'hC5, "R6 data ack", 1);
    reg_read(3'd2, rd); chk("R6 rx byte", rd, 8'hC5);
    reg_write(3'd4, 8'h00);
    send_byte(8'h5A, "R6 data ack 2", 1);
    reg_read(3'd2, rd); chk("R6 rx byte 2", rd, 8'h5A);
    reg_write(3'd4, 8'h00);
    bus_stop();

    // R3 mismatch
    bus_start();
    send_byte(8'h76, "R3 mismatch nack", 0);
    send_byte(8'hFF, "R3 silent after mismatch", 0);
    reg_read(3'd4, rd); chk("R3 no ready", rd[0], 0);
    chk("R3 no stretch", scl_oe, 0);
    bus_stop();

    // R8 read transfer
    reg_write(3'd3, 8'hA6);
    bus_start();
    send_byte(8'h75, "R2 read address ack", 1);
    reg_read(3'd4, rd); chk("R4 read dir", rd, 8'h03);
    reg_write(3'd4, 8'h00);
    recv_byte(1'b0, "R8 tx byte", 8'hA6);
    chk("R8 stretch after master ack", scl_oe, 1);
    reg_read(3'd4, rd); chk("R8 status after ack", rd, 8'h03);
    reg_write(3'd3, 8'h3C);
    reg_write(3'd4, 8'h00);
    recv_byte(1'b1, "R8 tx byte 2", 8'h3C);
    reg_read(3'd4, rd); chk("R8 status after nack", rd, 8'h06);
    chk("R8 lines released", {scl_oe, sda_oe}, 0);
    bus_stop();

    // repeated START: R2 R4
    bus_start();
    send_byte(8'h74, "R2 write then restart", 1);
    reg_write(3'd4, 8'h00);
    bus_start();
    send_byte(8'h75, "R2 repeated start ack", 1);
    reg_read(3'd4, rd); chk("R4 dir after restart", rd, 8'h03);
    reg_write(3'd3, 8'h81);
    reg_write(3'd4, 8'h00);
    recv_byte(1'b1, "R8 tx after restart", 8'h81);
    bus_stop();

    // R7 refuse control
    reg_write(3'd0, 8'h07);
    bus_start();
    send_byte(8'h74, "R7 address refused", 0);
    bus_stop();
    reg_write(3'd0, 8'h05);
    bus_start();
    send_byte(8'h74, "R2 ack before refuse", 1);
    reg_write(3'd0, 8'h07);
    reg_write(3'd4, 8'h00);
    send_byte(8'h99, "R7 data nack", 0);
    reg_read(3'd2, rd); chk("R7 byte not stored", rd, 8'h5A);
    reg_read(3'd4, rd); chk("R7 no ready", rd[0], 0);
    chk("R7 no stretch", scl_oe, 0);
    bus_stop();
    reg_write(3'd0, 8'h05);

    // R9 STOP mid-byte
    bus_start();
    send_byte(8'h74, "R9 setup ack", 1);
    reg_write(3'd4, 8'h00);
    clock_bit(1'b1, r); clock_bit(1'b0, r); clock_bit(1'b1, r);
    bus_stop();
    chk("R9 idle lines", {scl_oe, sda_oe}, 0);
    m_scl_low = 1'b1; wait_q();
    send_byte(8'h74, "R9 no start ignored", 0);
    bus_stop();
    bus_start();
    send_byte(8'h74, "R9 new transfer ack", 1);
    reg_write(3'd4, 8'h00);
    send_byte(8'h3C, "R9 data ack", 1);
    reg_read(3'd2, rd); chk("R9 rx byte", rd, 8'h3C);
    reg_write(3'd4, 8'h00);
    bus_stop();

    // R3 disabled, R5 irq gating
    reg_write(3'd0, 8'h04);
    bus_start();
    send_byte(8'h74, "R3 disabled nack", 0);
    bus_stop();
    reg_write(3'd0, 8'h01);
    bus_start();
    send_byte(8'h74, "R2 ack irq off", 1);
    chk("R5 irq gated", irq, 0);
    reg_write(3'd4, 8'h00);
    bus_stop();

    repeat (5) @(negedge clk);
    chk("R10 sda only with scl low", r10_viol, 0);
    chk("scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule